// File: doc/BRIEF.md
# AUX Request Header Packer

This block turns one auxiliary-channel request into the byte stream that the channel transmitter sends, and turns the transmitter's answer into a result. A request gives a 20-bit target address, a 4-bit command, a payload length and, for writes, up to sixteen payload bytes. The block accepts it with a valid/ready handshake. It checks the request, builds a four-byte header, and streams the header and any write payload one byte per cycle on a valid/ready byte port.

After the last byte, the block waits for the transmitter's reply: a status byte and the number of bytes that came back. It then pulses a one-cycle completion with a result code, the reply nibble and a byte count. A request that fails its checks completes at once and sends no bytes. The block holds one request at a time. It stays busy from acceptance until the completion pulse.

Result codes on `done_result`: 0 = success, 1 = timeout, 2 = I/O error, 3 = payload too large, 4 = invalid command.

Top module: `aux_req_packer`

## Requirements
- R1: Header byte 0 carries address bits [7:0] and header byte 1 carries address bits [15:8]; the header goes out first, byte 0 first.
- R2: Header byte 2 carries the command in bits [7:4] and address bits [19:16] in bits [3:0].
- R3: Bits [3:0] of header byte 3 are the payload length minus one, or 0 for a zero length.
- R4: Bits [7:4] of header byte 3 are 3 when the length is zero. Otherwise they are the transmit size modulo 16. The transmit size is 4 plus the length for writes and 4 for reads.
- R5: A write sends its payload bytes after the header, payload byte k taken from `req_payload[8k+7:8k]`. A read sends only the four header bytes. `tx_last` marks the final byte of every request.
- R6: A request whose length exceeds 16 completes on the cycle after acceptance with result 3, count 0 and reply 0, and sends no byte.
- R7: With command bit 2 cleared, only the values 0 (bus write), 1 (bus read), 8 (native write) and 9 (native read) are valid. Any other command completes on the cycle after acceptance with result 4 and sends no byte.
- R8: A reply status byte of 0x01 gives result 1. A status of 0x02 or 0x03 gives result 2. Both report count 0 and reply 0.
- R9: Any other status gives result 0 with reply equal to status bits [7:4]. For reads, the count is the received count clipped to the requested length.
- R10: A successful write reports its payload length as the count, whatever received count is supplied.
- R11: `req_ready` stays low and no request is taken from acceptance until the completion pulse. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when both high |
| req_addr | input | 20 | Target address |
| req_cmd | input | 4 | Request command |
| req_len | input | 5 | Payload length in bytes |
| req_payload | input | 128 | Write payload, byte k at bits [8k+7:8k] |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the request |
| rsp_valid | input | 1 | Reply available (taken only while waiting) |
| rsp_status | input | 8 | Reply status byte |
| rsp_count | input | 5 | Bytes received by the transmitter |
| busy | output | 1 | Request in flight |
| done_valid | output | 1 | One-cycle completion pulse |
| done_result | output | 3 | Result code |
| done_reply | output | 4 | Reply nibble |
| done_count | output | 5 | Reported byte count |

## Verification
The hardest case to reach from the ports is the length nibble at its wrap points. A 12-byte write gives a transmit size of 16, which wraps to 0 in the upper nibble. A 16-byte write wraps to 4. A zero-length request forces the value 3 for both reads and writes. The directed tests send writes of exactly those lengths and zero-length requests in both directions. The 16-byte write also runs with a stalling byte consumer, so the hold rule applies over a long stream. A second request offered while the first waits for its reply shows that the busy window rejects it at the ports.

// File: rtl/aux_pkg.sv
// Shared types and command encodings for the AUX request packer.
// Assumes a 4-bit command field in which bit 2 is the middle-of-transaction flag.
package aux_pkg;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_TIMEOUT = 3'd1,
        RES_IOERR   = 3'd2,
        RES_TOOBIG  = 3'd3,
        RES_BADCMD  = 3'd4
    } aux_result_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } aux_state_e;

    localparam logic [3:0] CMD_BUS_WR  = 4'h0;
    localparam logic [3:0] CMD_BUS_RD  = 4'h1;
    localparam logic [3:0] CMD_NAT_WR  = 4'h8;
    localparam logic [3:0] CMD_NAT_RD  = 4'h9;
    localparam logic [3:0] CMD_MOT_BIT = 4'h4;

    localparam int HDR_BYTES = 4;

endpackage

// File: rtl/aux_hdr_build.sv
// Combinational header builder: classifies the command and forms the four
// header bytes and the transmit size from address, command and length.
// Assumes the length has already been range-checked by the caller.
module aux_hdr_build
    import aux_pkg::*;
#(
    parameter int LEN_W  = 5,
    parameter int SIZE_W = 5
) (
    input  logic [19:0]       addr,
    input  logic [3:0]        cmd,
    input  logic [LEN_W-1:0]  len,
    output logic [3:0][7:0]   hdr,
    output logic              cmd_ok,
    output logic              is_write,
    output logic [SIZE_W-1:0] tx_size
);

    logic [3:0]       base_cmd;
    logic [LEN_W-1:0] len_m1;
    logic [3:0]       len_nib;
    logic [3:0]       size_nib;

    // Classify the command with the middle-of-transaction flag ignored.
    always_comb begin
        base_cmd = cmd & ~CMD_MOT_BIT;
        is_write = (base_cmd == CMD_BUS_WR) || (base_cmd == CMD_NAT_WR);
        cmd_ok   = is_write || (base_cmd == CMD_BUS_RD) || (base_cmd == CMD_NAT_RD);
    end

    // Transmit size and the two nibbles of the length byte.
    always_comb begin
        tx_size  = is_write ? (SIZE_W'(len) + SIZE_W'(HDR_BYTES)) : SIZE_W'(HDR_BYTES);
        len_m1   = len - LEN_W'(1);
        len_nib  = (len == '0) ? 4'd0 : len_m1[3:0];
        size_nib = (len == '0) ? 4'd3 : tx_size[3:0];
    end

    // Assemble the header bytes in transmit order.
    always_comb begin
        hdr[0] = addr[7:0];
        hdr[1] = addr[15:8];
        hdr[2] = {cmd, addr[19:16]};
        hdr[3] = {size_nib, len_nib};
    end

endmodule

// File: rtl/aux_reply_decode.sv
// Combinational reply decoder: maps the status byte to a result code and
// derives the reported reply nibble and byte count.
// Assumes it is sampled only when a reply is taken in the wait state.
module aux_reply_decode
    import aux_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic [7:0]       status,
    input  logic [LEN_W-1:0] rx_count,
    input  logic [LEN_W-1:0] req_len,
    input  logic             is_write,
    output aux_result_e      result,
    output logic [3:0]       reply,
    output logic [LEN_W-1:0] count
);

    logic [LEN_W-1:0] clipped;

    // Clip the received count to what was asked for.
    always_comb clipped = (rx_count > req_len) ? req_len : rx_count;

    // Status classification and success outputs.
    always_comb begin
        result = RES_OK;
        reply  = status[7:4];
        count  = is_write ? req_len : clipped;
        if (status == 8'h01) begin
            result = RES_TIMEOUT;
        end else if ((status == 8'h02) || (status == 8'h03)) begin
            result = RES_IOERR;
        end
        if (result != RES_OK) begin
            reply = 4'd0;
            count = '0;
        end
    end

endmodule

// File: rtl/aux_req_packer.sv
// AUX request packer top: accepts one request, validates it, streams the
// header and write payload one byte per cycle, then waits for the reply and
// pulses a completion. One request in flight; ready is low while busy.
// Assumes rsp_valid is meaningful only after the last byte has been sent.
module aux_req_packer
    import aux_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [19:0]              req_addr,
    input  logic [3:0]               req_cmd,
    input  logic [$clog2(MAX_PAYLOAD+1)-1:0] req_len,
    input  logic [MAX_PAYLOAD*8-1:0] req_payload,
    output logic                     tx_valid,
    input  logic                     tx_ready,
    output logic [7:0]               tx_data,
    output logic                     tx_last,
    input  logic                     rsp_valid,
    input  logic [7:0]               rsp_status,
    input  logic [$clog2(MAX_PAYLOAD+1)-1:0] rsp_count,
    output logic                     busy,
    output logic                     done_valid,
    output logic [2:0]               done_result,
    output logic [3:0]               done_reply,
    output logic [$clog2(MAX_PAYLOAD+1)-1:0] done_count
);

    localparam int LEN_W  = $clog2(MAX_PAYLOAD + 1);
    localparam int SIZE_W = $clog2(MAX_PAYLOAD + HDR_BYTES + 1);
    localparam int PIDX_W = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1;

    aux_state_e                   state;
    logic [3:0][7:0]              hdr_q;
    logic [MAX_PAYLOAD-1:0][7:0]  pay_q;
    logic                         wr_q;
    logic [LEN_W-1:0]             len_q;
    logic [SIZE_W-1:0]            size_q;
    logic [SIZE_W-1:0]            cnt_q;

    logic [3:0][7:0]              hdr_c;
    logic                         cmd_ok_c;
    logic                         is_wr_c;
    logic [SIZE_W-1:0]            size_c;
    logic                         too_big_c;

    aux_result_e                  dec_result;
    logic [3:0]                   dec_reply;
    logic [LEN_W-1:0]             dec_count;

    logic [SIZE_W-1:0]            poff;
    logic                         at_end;

    aux_hdr_build #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_hdr (
        .addr     (req_addr),
        .cmd      (req_cmd),
        .len      (req_len),
        .hdr      (hdr_c),
        .cmd_ok   (cmd_ok_c),
        .is_write (is_wr_c),
        .tx_size  (size_c)
    );

    aux_reply_decode #(.LEN_W(LEN_W)) u_dec (
        .status   (rsp_status),
        .rx_count (rsp_count),
        .req_len  (len_q),
        .is_write (wr_q),
        .result   (dec_result),
        .reply    (dec_reply),
        .count    (dec_count)
    );

    // Length range check against the payload buffer size.
    always_comb too_big_c = (req_len > LEN_W'(MAX_PAYLOAD));

    // Handshake and status outputs derived from the state.
    always_comb begin
        busy      = (state != ST_IDLE);
        req_ready = (state == ST_IDLE);
        tx_valid  = (state == ST_SEND);
        at_end    = (cnt_q == size_q - SIZE_W'(1));
        tx_last   = (state == ST_SEND) && at_end;
    end

    // Byte selection: header first, then payload bytes in index order.
    always_comb begin
        poff = cnt_q - SIZE_W'(HDR_BYTES);
        if (cnt_q < SIZE_W'(HDR_BYTES)) begin
            tx_data = hdr_q[cnt_q[1:0]];
        end else begin
            tx_data = pay_q[poff[PIDX_W-1:0]];
        end
    end

    // Request sequencing: accept, stream, wait for reply, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            hdr_q       <= '0;
            pay_q       <= '0;
            wr_q        <= 1'b0;
            len_q       <= '0;
            size_q      <= SIZE_W'(HDR_BYTES);
            cnt_q       <= '0;
            done_valid  <= 1'b0;
            done_result <= RES_OK;
            done_reply  <= 4'd0;
            done_count  <= '0;
        end else begin
            done_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (too_big_c || !cmd_ok_c) begin
                            done_valid  <= 1'b1;
                            done_result <= too_big_c ? RES_TOOBIG : RES_BADCMD;
                            done_reply  <= 4'd0;
                            done_count  <= '0;
                        end else begin
                            hdr_q  <= hdr_c;
                            pay_q  <= req_payload;
                            wr_q   <= is_wr_c;
                            len_q  <= req_len;
                            size_q <= size_c;
                            cnt_q  <= '0;
                            state  <= ST_SEND;
                        end
                    end
                end
                ST_SEND: begin
                    if (tx_ready) begin
                        if (at_end) begin
                            state <= ST_WAIT;
                        end else begin
                            cnt_q <= cnt_q + SIZE_W'(1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        done_valid  <= 1'b1;
                        done_result <= dec_result;
                        done_reply  <= dec_reply;
                        done_count  <= dec_count;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/aux_req_packer_chk.sv
// Checker for the AUX request packer: port-level temporal properties,
// attached to every instance of the top by the bind below.
// Assumes reset is asserted from time zero.
module aux_req_packer_chk #(
    parameter int MAX_PAYLOAD = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [3:0]               req_cmd,
    input logic [$clog2(MAX_PAYLOAD+1)-1:0] req_len,
    input logic                     tx_valid,
    input logic                     tx_ready,
    input logic [7:0]               tx_data,
    input logic                     tx_last,
    input logic                     rsp_valid,
    input logic [7:0]               rsp_status,
    input logic                     busy,
    input logic                     done_valid,
    input logic [2:0]               done_result,
    input logic [$clog2(MAX_PAYLOAD+1)-1:0] done_count
);

    localparam int LEN_W = $clog2(MAX_PAYLOAD + 1);

    logic [3:0] base_cmd;
    logic       cmd_bad;
    always_comb begin
        base_cmd = req_cmd & 4'b1011;
        cmd_bad  = !((base_cmd == 4'h0) || (base_cmd == 4'h1) ||
                     (base_cmd == 4'h8) || (base_cmd == 4'h9));
    end

    // R11: no byte is offered outside a request
    a_r11_no_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_valid);

    // R11: a stalled byte holds its value and marker
    a_r11_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R6: oversize request completes at once with no byte sent
    a_r6_oversize: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len > LEN_W'(MAX_PAYLOAD)))
        |=> (done_valid && (done_result == 3'd3) && !tx_valid));

    // R7: unknown command completes at once and leaves the block idle
    a_r7_bad_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len <= LEN_W'(MAX_PAYLOAD)) && cmd_bad)
        |=> (done_valid && (done_result == 3'd4) && !busy));

    // R8: timeout status maps to result 1 with a zero count
    a_r8_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_valid && rsp_valid && (rsp_status == 8'h01))
        |=> (done_valid && (done_result == 3'd1) && (done_count == '0)));

    // R9: a successful count never exceeds the payload limit
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && (done_result == 3'd0)) |-> (done_count <= LEN_W'(MAX_PAYLOAD)));

endmodule

bind aux_req_packer aux_req_packer_chk #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_cmd     (req_cmd),
    .req_len     (req_len),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .busy        (busy),
    .done_valid  (done_valid),
    .done_result (done_result),
    .done_count  (done_count)
);

// File: tb/aux_req_packer_tb.sv
`timescale 1ns/1ps
module aux_req_packer_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [19:0]  req_addr = '0;
    logic [3:0]   req_cmd = '0;
    logic [4:0]   req_len = '0;
    logic [127:0] req_payload = '0;
    logic         tx_valid;
    logic         tx_ready = 1'b1;
    logic [7:0]   tx_data;
    logic         tx_last;
    logic         rsp_valid = 1'b0;
    logic [7:0]   rsp_status = '0;
    logic [4:0]   rsp_count = '0;
    logic         busy;
    logic         done_valid;
    logic [2:0]   done_result;
    logic [3:0]   done_reply;
    logic [4:0]   done_count;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] rx [0:31];
    int n_rx;

    always #4 clk = ~clk;

    aux_req_packer u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_len(req_len), .req_payload(req_payload),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_count(rsp_count),
        .busy(busy), .done_valid(done_valid), .done_result(done_result),
        .done_reply(done_reply), .done_count(done_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue a request and collect the streamed bytes.
    task automatic send(input logic [19:0] a, input logic [3:0] c, input int len,
                        input bit stall);
        bit got_last = 0;
        @(negedge clk);
        req_addr = a; req_cmd = c; req_len = 5'(len); req_valid = 1'b1;
        for (int k = 0; k < 16; k++) req_payload[8*k +: 8] = 8'((k * 7 + 1) ^ len);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 ready low while sending", int'(req_ready), 0);
        n_rx = 0;
        for (int i = 0; i < 100 && !got_last; i++) begin
            tx_ready = stall ? (i % 3 != 2) : 1'b1;
            #1;
            if (tx_valid && tx_ready) begin
                rx[n_rx] = tx_data;
                n_rx++;
                if (tx_last) got_last = 1;
            end
            @(negedge clk);
        end
        tx_ready = 1'b1;
    endtask

    // Compare the collected stream to the expected header and payload.
    task automatic check_stream(input logic [19:0] a, input logic [3:0] c, input int len,
                                input bit wr);
        int size = wr ? 4 + len : 4;
        logic [3:0] up  = (len == 0) ? 4'd3 : 4'(size);
        logic [3:0] low = (len == 0) ? 4'd0 : 4'(len - 1);
        chk("R5 byte count", n_rx, size);
        chk("R1 byte0", int'(rx[0]), int'(a[7:0]));
        chk("R1 byte1", int'(rx[1]), int'(a[15:8]));
        chk("R2 byte2", int'(rx[2]), int'({c, a[19:16]}));
        chk("R3 R4 byte3", int'(rx[3]), int'({up, low}));
        if (wr)
            for (int k = 0; k < len; k++)
                chk("R5 payload byte", int'(rx[4 + k]), int'(8'((k * 7 + 1) ^ len)));
    endtask

    // Supply the reply and check the completion.
    task automatic reply(input logic [7:0] st, input int cnt, input int e_res,
                         input int e_rep, input int e_cnt, input string tag);
        chk("R11 ready low while waiting", int'(req_ready), 0);
        rsp_valid = 1'b1; rsp_status = st; rsp_count = 5'(cnt);
        @(negedge clk);
        rsp_valid = 1'b0;
        chk({tag, " done"}, int'(done_valid), 1);
        chk({tag, " result"}, int'(done_result), e_res);
        chk({tag, " reply"}, int'(done_reply), e_rep);
        chk({tag, " count"}, int'(done_count), e_cnt);
        @(negedge clk);
        chk({tag, " pulse ends"}, int'(done_valid), 0);
    endtask

    task automatic reject(input logic [3:0] c, input int len, input int e_res, input string tag);
        @(negedge clk);
        req_addr = 20'h12345; req_cmd = c; req_len = 5'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " done"}, int'(done_valid), 1);
        chk({tag, " result"}, int'(done_result), e_res);
        chk({tag, " no tx"}, int'(tx_valid), 0);
        chk({tag, " count"}, int'(done_count), 0);
        chk({tag, " idle"}, int'(busy), 0);
    endtask

    task automatic t_reset();
        chk("R11 reset busy", int'(busy), 0);
        chk("R11 reset ready", int'(req_ready), 1);
        chk("R11 reset tx", int'(tx_valid), 0);
        chk("R11 reset done", int'(done_valid), 0);
    endtask

    task automatic t_native_read_clip();
        send(20'hA1234, 4'h9, 16, 0);
        check_stream(20'hA1234, 4'h9, 16, 0);
        reply(8'h00, 20, 0, 0, 16, "R9 read clip");
    endtask

    task automatic t_native_write();
        send(20'h00102, 4'h8, 3, 0);
        check_stream(20'h00102, 4'h8, 3, 1);
        reply(8'h20, 0, 0, 2, 3, "R10 write ok");
    endtask

    task automatic t_zero_write_timeout();
        send(20'h00050, 4'h4, 0, 0);
        check_stream(20'h00050, 4'h4, 0, 1);
        reply(8'h01, 3, 1, 0, 0, "R8 timeout");
    endtask

    task automatic t_zero_read_ioerr();
        send(20'hF0050, 4'h5, 0, 0);
        check_stream(20'hF0050, 4'h5, 0, 0);
        reply(8'h02, 0, 2, 0, 0, "R8 flags");
    endtask

    task automatic t_full_write_stall();
        send(20'h5A5A5, 4'hC, 16, 1);
        check_stream(20'h5A5A5, 4'hC, 16, 1);
        reply(8'h03, 0, 2, 0, 0, "R8 error");
    endtask

    task automatic t_wrap_write();
        send(20'h3C3C3, 4'h0, 12, 0);
        check_stream(20'h3C3C3, 4'h0, 12, 1);
        reply(8'h10, 9, 0, 1, 12, "R10 write wrap");
    endtask

    task automatic t_short_read_busy();
        send(20'h7FFFF, 4'hD, 5, 0);
        check_stream(20'h7FFFF, 4'hD, 5, 0);
        req_valid = 1'b1; req_len = 5'd20; req_cmd = 4'h2;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 request while busy ignored", int'(done_valid), 0);
        chk("R11 still busy", int'(busy), 1);
        reply(8'h00, 2, 0, 0, 2, "R9 short read");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_native_read_clip();
        t_native_write();
        t_zero_write_timeout();
        t_zero_read_ioerr();
        t_full_write_stall();
        t_wrap_write();
        t_short_read_busy();
        reject(4'h9, 17, 3, "R6 oversize");
        reject(4'h2, 4, 4, "R7 bad cmd 2");
        reject(4'hA, 0, 4, "R7 bad cmd A");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule